// File: doc/BRIEF.md
# Dual-Pixel Display Link Formatter

This block packs parallel RGB pixels, with their horizontal sync, vertical sync and data-enable bits, into the serial words of one or two display links. Each link has four data lanes and one clock lane. Every lane sends seven bits per link word. Everything runs from one bit clock at seven times the link word rate. The pixel clock is an ordinary input that is sampled in that domain, and a chosen edge of it captures a pixel pair.

A two-bit mode input selects how the pixels are routed:

- **Dual link:** the first pixel goes to link 1 and the second to link 2.
- **Split:** both pixels go to link 1 in consecutive words, at twice the pixel rate.
- **Single:** only the first pixel goes to link 1.

In both single-link modes, link 2 is switched off. A 6-bit colour select blanks the fourth lane of each link. Output-enable and power-down inputs take the links off the wire. High impedance is modelled as a valid flag held low, with every lane bit forced to 0.

Top module: `dual_link_formatter`

## Requirements
- R1: After reset, link1Valid and link2Valid are low and every lane and clock output is 0. This holds until the first word boundary.
- R2: A link word is 28 bits, with lane k holding word bits 7k+6..7k. Each lane sends its 7 bits least significant first, one per bitClk cycle. Lane 0 holds R[5:0] in bits 0-5 and G[0] in bit 6. Lane 1 holds G[5:1] in bits 0-4, B[0] in bit 5 and B[1] in bit 6. Lane 2 holds B[5:2] in bits 0-3, hsync in bit 4, vsync in bit 5 and de in bit 6. Lane 3 holds R[7:6] in bits 0-1, G[7:6] in bits 2-3, B[7:6] in bits 4-5, and 0 in bit 6. Pixel inputs are packed {R,G,B}, with R in bits 23:16.
- R3: Each valid clock lane sends 1,1,0,0,0,1,1 over the seven bits of every word, first bit first.
- R4: In mode 00 (dual link), link 1 carries the first pixel and link 2 carries the second pixel. Both links carry the same sync bits and both are valid.
- R5: In mode 01 (split), the first two words loaded after a capture carry the first pixel and then the second pixel on link 1. Link 2 is not valid.
- R6: In mode 11 (single), every word on link 1 carries the first pixel, and the second pixel input is ignored. Link 2 is not valid.
- R7: Mode code 10 is ignored, and the previously active mode stays in force.
- R8: With edgeSel high, pixels are captured on a rising edge of pixClk. With edgeSel low, they are captured on a falling edge. An edge of the other direction changes nothing.
- R9: With sixBitSel high, lane 3 of both links sends only zeros, starting from the next word loaded.
- R10: With outEn low, both valid flags are low and all link outputs are 0 from the same cycle. Raising outEn resumes the running word stream.
- R11: With pwrDnN low at a word boundary, both links become invalid. Captures made while powered down are discarded, and the capture registers are cleared. The first word after power returns carries all-zero data.
- R12: A change on modeSel or pwrDnN affects the outputs only from the next word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven cycles per link word |
| rstN | input | 1 | Active-low synchronous reset |
| pixClk | input | 1 | Pixel clock, sampled in the bit clock domain |
| edgeSel | input | 1 | Capture edge: 1 rising, 0 falling |
| modeSel | input | 2 | 00 dual link, 01 split, 11 single, 10 ignored |
| sixBitSel | input | 1 | 1 blanks lane 3 of both links |
| outEn | input | 1 | 0 takes both links off the wire at once |
| pwrDnN | input | 1 | 0 powers the links down at a word boundary |
| pixFirst | input | 24 | First pixel {R,G,B} |
| pixSecond | input | 24 | Second pixel {R,G,B} |
| hsyncIn | input | 1 | Horizontal sync, shared by both pixels |
| vsyncIn | input | 1 | Vertical sync, shared by both pixels |
| deIn | input | 1 | Data enable, shared by both pixels |
| link1Lanes | output | 4 | Link 1 data lane bits |
| link1Clk | output | 1 | Link 1 clock lane bit |
| link1Valid | output | 1 | Link 1 driven; 0 models high impedance |
| link2Lanes | output | 4 | Link 2 data lane bits |
| link2Clk | output | 1 | Link 2 clock lane bit |
| link2Valid | output | 1 | Link 2 driven; 0 models high impedance |

## Verification
The assertions check on every cycle the rules that hold whatever the pixels are:

- the bit counter stays inside its range;
- the active mode and power state move only at a word boundary, and the active mode is never the unused code;
- each clock lane starts every word with a 1;
- lane 3 is blank after a 6-bit load, and link 2 is blank when it is not filled;
- the capture registers are empty while powered down;
- link 2 is never valid without link 1.

Only the scenarios can show the parts that depend on data and ordering. These are the bit map itself, first-then-second pixel order in split mode, capture on the chosen edge only, the held mode under code 10, the all-zero first word after wake-up, and the one-word delay of a mode or power change.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  localparam int LINKS     = 2;
  localparam int LANE_CNT  = 4;
  localparam int LANE_BITS = 7;
  localparam int WORD_W    = LANE_CNT * LANE_BITS;
  localparam int PIX_W     = 24;

  localparam logic [LANE_BITS-1:0] CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pixel_t;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } sync_t;

  typedef enum logic [1:0] {
    MODE_DUAL   = 2'b00,
    MODE_SPLIT  = 2'b01,
    MODE_UNDEF  = 2'b10,
    MODE_SINGLE = 2'b11
  } mode_e;

  typedef struct packed {
    logic capture;
    logic clearCap;
    logic load;
    logic pickSecond;
    logic link2Fill;
    logic blankAll;
    logic sixBit;
  } strobe_t;

  function automatic logic [WORD_W-1:0] packWord(pixel_t p, sync_t s, logic six);
    logic [LANE_BITS-1:0] l0, l1, l2, l3;
    l0 = {p.g[0], p.r[5:0]};
    l1 = {p.b[1:0], p.g[5:1]};
    l2 = {s.de, s.vs, s.hs, p.b[5:2]};
    l3 = six ? '0 : {1'b0, p.b[7:6], p.g[7:6], p.r[7:6]};
    return {l3, l2, l1, l0};
  endfunction
endpackage

// File: rtl/dlf_ctrl.sv
module dlf_ctrl
  import dlf_pkg::*;
#(
  parameter int BITS = LANE_BITS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixClk,
  input  logic       edgeSel,
  input  logic [1:0] modeSel,
  input  logic       sixBitSel,
  input  logic       pwrDnN,
  output strobe_t    stb,
  output logic       link1On,
  output logic       link2On
);
  localparam int CNT_W = $clog2(BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic [CNT_W-1:0] bitIdx;
  logic             prevPix;
  logic             on;
  logic             firstDue;
  mode_e            activeMode;
  mode_e            nextMode;
  logic             boundary;
  logic             edgeEv;

  always_comb begin
    boundary = (bitIdx == LAST);
    edgeEv   = edgeSel ? (pixClk & ~prevPix) : (~pixClk & prevPix);
    nextMode = (modeSel == MODE_UNDEF) ? activeMode : mode_e'(modeSel);

    stb.capture    = edgeEv & on;
    stb.clearCap   = ~on;
    stb.load       = boundary;
    stb.pickSecond = (nextMode == MODE_SPLIT) & ~firstDue;
    stb.link2Fill  = (nextMode == MODE_DUAL);
    stb.blankAll   = ~pwrDnN;
    stb.sixBit     = sixBitSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx     <= '0;
      prevPix    <= 1'b0;
      on         <= 1'b0;
      firstDue   <= 1'b0;
      activeMode <= MODE_DUAL;
    end else begin
      prevPix <= pixClk;
      bitIdx  <= boundary ? '0 : bitIdx + CNT_W'(1);
      if (boundary) begin
        activeMode <= nextMode;
        on         <= pwrDnN;
      end
      if (!on)              firstDue <= 1'b0;
      else if (stb.capture) firstDue <= 1'b1;
      else if (boundary)    firstDue <= 1'b0;
    end
  end

  assign link1On = on;
  assign link2On = on && (activeMode == MODE_DUAL);

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= LAST);

  // R12
  word_edge_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(activeMode) && $stable(on));

  // R7
  undef_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeMode != MODE_UNDEF);
endmodule

// File: rtl/dlf_datapath.sv
module dlf_datapath
  import dlf_pkg::*;
#(
  parameter int BITS = LANE_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [PIX_W-1:0]    pixFirst,
  input  logic [PIX_W-1:0]    pixSecond,
  input  sync_t               syncIn,
  output logic [LANE_CNT-1:0] lanes1,
  output logic                clkBit1,
  output logic [LANE_CNT-1:0] lanes2,
  output logic                clkBit2
);
  pixel_t capA, capB;
  sync_t  capSync;

  logic [WORD_W-1:0]   loadWord [LINKS];
  logic [LANE_CNT-1:0] laneBit  [LINKS];
  logic                clkBit   [LINKS];

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearCap) begin
      capA    <= '0;
      capB    <= '0;
      capSync <= '0;
    end else if (stb.capture) begin
      capA    <= pixel_t'(pixFirst);
      capB    <= pixel_t'(pixSecond);
      capSync <= syncIn;
    end
  end

  always_comb begin
    loadWord[0] = stb.blankAll ? '0 :
                  packWord(stb.pickSecond ? capB : capA, capSync, stb.sixBit);
    loadWord[1] = (stb.blankAll || !stb.link2Fill) ? '0 :
                  packWord(capB, capSync, stb.sixBit);
  end

  for (genvar l = 0; l < LINKS; l++) begin : g_link
    logic [BITS-1:0] clkSr;
    always_ff @(posedge clk) begin
      if (!rstN)         clkSr <= '0;
      else if (stb.load) clkSr <= CLK_PATTERN;
      else               clkSr <= clkSr >> 1;
    end
    assign clkBit[l] = clkSr[0];

    for (genvar k = 0; k < LANE_CNT; k++) begin : g_lane
      logic [BITS-1:0] sr;
      always_ff @(posedge clk) begin
        if (!rstN)         sr <= '0;
        else if (stb.load) sr <= loadWord[l][k*BITS +: BITS];
        else               sr <= sr >> 1;
      end
      assign laneBit[l][k] = sr[0];
    end
  end

  assign lanes1  = laneBit[0];
  assign lanes2  = laneBit[1];
  assign clkBit1 = clkBit[0];
  assign clkBit2 = clkBit[1];

  // R3
  clk_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> clkBit1 && clkBit2);

  // R9
  six_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load && stb.sixBit |=> !lanes1[LANE_CNT-1] && !lanes2[LANE_CNT-1]);

  // R5
  link2_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load && !stb.link2Fill |=> lanes2 == '0);

  // R11
  cap_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearCap |=> capA == '0 && capB == '0);
endmodule

// File: rtl/dual_link_formatter.sv
module dual_link_formatter
  import dlf_pkg::*;
#(
  parameter int BITS = LANE_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pixClk,
  input  logic                edgeSel,
  input  logic [1:0]          modeSel,
  input  logic                sixBitSel,
  input  logic                outEn,
  input  logic                pwrDnN,
  input  logic [PIX_W-1:0]    pixFirst,
  input  logic [PIX_W-1:0]    pixSecond,
  input  logic                hsyncIn,
  input  logic                vsyncIn,
  input  logic                deIn,
  output logic [LANE_CNT-1:0] link1Lanes,
  output logic                link1Clk,
  output logic                link1Valid,
  output logic [LANE_CNT-1:0] link2Lanes,
  output logic                link2Clk,
  output logic                link2Valid
);
  strobe_t             stb;
  logic                link1On, link2On;
  logic [LANE_CNT-1:0] raw1, raw2;
  logic                rawClk1, rawClk2;
  sync_t               syncIn;

  assign syncIn = '{hs: hsyncIn, vs: vsyncIn, de: deIn};

  dlf_ctrl #(.BITS(BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixClk(pixClk), .edgeSel(edgeSel),
    .modeSel(modeSel), .sixBitSel(sixBitSel), .pwrDnN(pwrDnN),
    .stb(stb), .link1On(link1On), .link2On(link2On)
  );

  dlf_datapath #(.BITS(BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pixFirst(pixFirst),
    .pixSecond(pixSecond), .syncIn(syncIn),
    .lanes1(raw1), .clkBit1(rawClk1), .lanes2(raw2), .clkBit2(rawClk2)
  );

  assign link1Valid = link1On & outEn;
  assign link2Valid = link2On & outEn;
  assign link1Lanes = link1Valid ? raw1 : '0;
  assign link1Clk   = link1Valid & rawClk1;
  assign link2Lanes = link2Valid ? raw2 : '0;
  assign link2Clk   = link2Valid & rawClk2;

  // R5
  link2_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    link2Valid |-> link1Valid);
endmodule

// File: tb/dual_link_formatter_tb.sv
module dual_link_formatter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 0, rstN = 0, pixClk = 0, edgeSel = 1, sixBitSel = 0;
  logic outEn = 1, pwrDnN = 1, hsyncIn = 0, vsyncIn = 0, deIn = 0;
  logic [1:0]  modeSel = 2'b00;
  logic [23:0] pixFirst = 0, pixSecond = 0;
  logic [3:0]  link1Lanes, link2Lanes;
  logic        link1Clk, link1Valid, link2Clk, link2Valid;

  int checks = 0, fails = 0;
  logic [27:0] w1, w2;
  logic        v2;
  logic [6:0]  hc1, hc2;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_link_formatter u_dut (
    .clk(clk), .rstN(rstN), .pixClk(pixClk), .edgeSel(edgeSel),
    .modeSel(modeSel), .sixBitSel(sixBitSel), .outEn(outEn), .pwrDnN(pwrDnN),
    .pixFirst(pixFirst), .pixSecond(pixSecond), .hsyncIn(hsyncIn),
    .vsyncIn(vsyncIn), .deIn(deIn), .link1Lanes(link1Lanes),
    .link1Clk(link1Clk), .link1Valid(link1Valid), .link2Lanes(link2Lanes),
    .link2Clk(link2Clk), .link2Valid(link2Valid)
  );

  function automatic logic [27:0] expWord(input logic [23:0] px,
      input logic hs, input logic vs, input logic de, input logic six);
    logic [7:0] r, g, b;
    logic [27:0] w;
    r = px[23:16]; g = px[15:8]; b = px[7:0];
    w = '0;
    w[5:0]   = r[5:0];   w[6]     = g[0];
    w[11:7]  = g[5:1];   w[12]    = b[0];   w[13] = b[1];
    w[17:14] = b[5:2];   w[18]    = hs;     w[19] = vs;  w[20] = de;
    if (!six) begin
      w[22:21] = r[7:6]; w[24:23] = g[7:6]; w[26:25] = b[7:6];
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic getWord();
    logic [6:0] h1 [4];
    logic [6:0] h2 [4];
    for (int k = 0; k < 4; k++) begin h1[k] = '0; h2[k] = '0; end
    hc1 = '0; hc2 = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hc1 = {link1Clk, hc1[6:1]};
      hc2 = {link2Clk, hc2[6:1]};
      for (int k = 0; k < 4; k++) begin
        h1[k] = {link1Lanes[k], h1[k][6:1]};
        h2[k] = {link2Lanes[k], h2[k][6:1]};
      end
      if (hc1 == PAT) begin
        w1 = {h1[3], h1[2], h1[1], h1[0]};
        w2 = {h2[3], h2[2], h2[1], h2[0]};
        v2 = link2Valid;
        return;
      end
    end
    chk(0, "R3 no word boundary found", {21'd0, hc1}, {21'd0, PAT});
  endtask

  task automatic pushPix(input logic [23:0] a, input logic [23:0] b,
                         input logic hs, input logic vs, input logic de);
    @(negedge clk) pixClk = edgeSel ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    getWord();
    pixFirst = a; pixSecond = b; hsyncIn = hs; vsyncIn = vs; deIn = de;
    pixClk = edgeSel ? 1'b1 : 1'b0;
    getWord();
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    chk(!link1Valid && !link2Valid, "R1 valid after reset",
        {26'd0, link1Valid, link2Valid}, 28'd0);
    chk(link1Lanes == 0 && link2Lanes == 0 && !link1Clk && !link2Clk,
        "R1 outputs after reset",
        {18'd0, link1Lanes, link2Lanes, link1Clk, link2Clk}, 28'd0);
  endtask

  task automatic testDual(input logic [23:0] a, input logic [23:0] b,
                          input logic hs, input logic vs, input logic de);
    pushPix(a, b, hs, vs, de);
    getWord();
    chk(w1 == expWord(a, hs, vs, de, 0), "R2 R4 link1 word", w1,
        expWord(a, hs, vs, de, 0));
    chk(w2 == expWord(b, hs, vs, de, 0), "R4 link2 word", w2,
        expWord(b, hs, vs, de, 0));
    chk(v2 && hc2 == PAT, "R3 R4 link2 valid clock", {20'd0, v2, hc2},
        {20'd0, 1'b1, PAT});
  endtask

  task automatic testSix();
    sixBitSel = 1;
    pushPix(24'hC3A5F0, 24'hFFFFFF, 1, 0, 1);
    getWord();
    chk(w1 == expWord(24'hC3A5F0, 1, 0, 1, 1), "R9 link1 six bit", w1,
        expWord(24'hC3A5F0, 1, 0, 1, 1));
    chk(w2 == expWord(24'hFFFFFF, 1, 0, 1, 1), "R9 link2 six bit", w2,
        expWord(24'hFFFFFF, 1, 0, 1, 1));
    sixBitSel = 0;
  endtask

  task automatic testUndef();
    modeSel = 2'b10;
    pushPix(24'h123456, 24'h89ABCD, 0, 1, 1);
    getWord();
    chk(v2 && w2 == expWord(24'h89ABCD, 0, 1, 1, 0), "R7 code 10 keeps dual",
        w2, expWord(24'h89ABCD, 0, 1, 1, 0));
  endtask

  task automatic testSplit();
    modeSel = 2'b01;
    pushPix(24'h0F1E2D, 24'hE1D2C3, 1, 1, 1);
    getWord();
    chk(w1 == expWord(24'h0F1E2D, 1, 1, 1, 0), "R5 split first pixel", w1,
        expWord(24'h0F1E2D, 1, 1, 1, 0));
    chk(!v2, "R5 link2 off in split", {27'd0, v2}, 28'd0);
    getWord();
    chk(w1 == expWord(24'hE1D2C3, 1, 1, 1, 0), "R5 split second pixel", w1,
        expWord(24'hE1D2C3, 1, 1, 1, 0));
  endtask

  task automatic testSingle();
    modeSel = 2'b11;
    pushPix(24'h5A5A5A, 24'hA5A5A5, 0, 0, 1);
    getWord();
    chk(w1 == expWord(24'h5A5A5A, 0, 0, 1, 0), "R6 single word", w1,
        expWord(24'h5A5A5A, 0, 0, 1, 0));
    getWord();
    chk(w1 == expWord(24'h5A5A5A, 0, 0, 1, 0) && !v2,
        "R6 second pixel ignored", w1, expWord(24'h5A5A5A, 0, 0, 1, 0));
  endtask

  task automatic testEdge();
    getWord();
    pixFirst = 24'h777777;
    pixClk = 1'b0;
    getWord();
    getWord();
    chk(w1 == expWord(24'h5A5A5A, 0, 0, 1, 0), "R8 wrong edge ignored", w1,
        expWord(24'h5A5A5A, 0, 0, 1, 0));
    edgeSel = 0;
    pushPix(24'h3C3C3C, 24'h0, 1, 0, 0);
    getWord();
    chk(w1 == expWord(24'h3C3C3C, 1, 0, 0, 0), "R8 falling edge capture", w1,
        expWord(24'h3C3C3C, 1, 0, 0, 0));
    edgeSel = 1;
  endtask

  task automatic testOutEn();
    @(negedge clk) outEn = 0;
    @(negedge clk);
    chk(!link1Valid && !link2Valid && link1Lanes == 0 && !link1Clk,
        "R10 outputs off", {22'd0, link1Valid, link2Valid, link1Lanes}, 28'd0);
    outEn = 1;
    getWord();
    chk(w1 == expWord(24'h3C3C3C, 1, 0, 0, 0), "R10 stream resumes", w1,
        expWord(24'h3C3C3C, 1, 0, 0, 0));
  endtask

  task automatic testModeTiming();
    modeSel = 2'b00;
    testDual(24'h246801, 24'h135790, 1, 1, 0);
    getWord();
    repeat (2) @(negedge clk);
    modeSel = 2'b11;
    @(negedge clk);
    chk(link2Valid, "R12 mode waits for boundary", {27'd0, link2Valid}, 28'd1);
    getWord();
    getWord();
    chk(!v2, "R12 mode applied at boundary", {27'd0, v2}, 28'd0);
    modeSel = 2'b00;
  endtask

  task automatic testPower();
    testDual(24'hABCDEF, 24'hFEDCBA, 0, 1, 0);
    getWord();
    repeat (2) @(negedge clk);
    pwrDnN = 0;
    @(negedge clk);
    chk(link1Valid, "R12 power waits for boundary", {27'd0, link1Valid}, 28'd1);
    repeat (10) @(negedge clk);
    chk(!link1Valid && !link2Valid && link1Lanes == 0 && link2Lanes == 0,
        "R11 powered down", {22'd0, link1Valid, link2Valid, link1Lanes}, 28'd0);
    pixFirst = 24'h999999; pixSecond = 24'h888888;
    pixClk = 1'b0; repeat (3) @(negedge clk);
    pixClk = 1'b1; repeat (3) @(negedge clk);
    pwrDnN = 1;
    getWord();
    chk(w1 == 0 && w2 == 0, "R11 first word after wake is zero", w1 | w2, 28'd0);
    testDual(24'h010203, 24'h040506, 1, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testDual(24'h112233, 24'h445566, 1, 0, 1);
    testDual(24'hF00F81, 24'h7EC300, 0, 1, 0);
    testSix();
    testUndef();
    testSplit();
    testSingle();
    testEdge();
    testOutEn();
    testModeTiming();
    testPower();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule